// File: doc/BRIEF.md
# Chained Scatter-Gather DMA Channel

A single DMA channel that moves 32-bit words between a peripheral handshake port and a word-wide memory port. It holds two address pairs: an active pair (next address, limit) that the mover is working through, and a queued pair (start, stop) that software loads while the active segment is still running. When the active segment ends and software had armed the chain, the queued pair drops into the active pair in the same cycle and the transfer carries on without a gap. If the chain was not armed, the channel stops. Either way the completion flag is set and the interrupt line goes high until software acknowledges it.

Software programs the channel through a small indexed 32-bit register port. One index is a command/status register: writes are one-shot command bits and reads return live status flags. The other indices hold the two pairs and four saved copies. On every segment end the hardware writes the segment's first address and its final position into the saved next and saved limit copies, so the byte count of a short or aborted segment is the difference of the two. A synthesis option marks bit 31 of the limit and stop values as a side-band flag that is never part of an address.

The mover is a four-state machine. ST_IDLE waits for enable and moves to ST_CHECK. ST_CHECK compares next with limit: if the limit is reached it signals the segment end and stays in ST_CHECK (the chained pair is then checked, or enable has dropped and it returns to ST_IDLE); otherwise it moves to ST_SRC. ST_SRC takes one word from the source (peripheral in read direction, memory in write direction) and moves to ST_DST, or to ST_IDLE on a memory error. ST_DST delivers the word to the destination, advances next, and returns to ST_CHECK, or goes to ST_IDLE on a memory error. Any state returns to ST_IDLE when enable is found low.

Top module: `sgdma_channel`

## Requirements
- R1: After rst_n and after a command write with the reset bit (bit 5) the status flags enable (bit 0), chain-armed (bit 1), complete (bit 2), bus-exception (bit 3) and alignment-error (bit 5) read zero at index 0, a transfer in progress stops, and irq is low; the direction flag (bit 4) is kept by a reset command and cleared by rst_n.
- R2: With read direction (command bit 3), a command write with set-enable (bit 0) starts the channel; each word accepted from the peripheral (per_valid_in and per_ready_out) is written to memory at the active next address (index 1), and next advances by 4 for each word the memory acknowledges.
- R3: With write direction (command bit 4) each word read from memory at the next address is offered on per_data_out with per_valid_out until per_ready_in accepts it, in address order.
- R4: When next reaches the limit (index 2) with chain-armed clear, complete sets, enable clears, saved next (index 5) holds the segment's first address and saved limit (index 6) holds the final position, so their difference is the byte count; a segment with next equal to limit moves no word.
- R5: When next reaches the limit with chain-armed set (command bit 1), start (index 3) and stop (index 4) are copied into next and limit, chain-armed clears, complete sets and enable stays high, so the queued segment follows.
- R6: irq is high exactly while complete is set; a command write with clear-complete (bit 2) clears it unless a segment ends in the same cycle.
- R7: A memory error on any request stops the channel: bus-exception and complete set, enable clears, the failing word is not counted, and saved limit holds the address of the failing word.
- R8: With the transmit option, bit 31 of limit and stop is a flag kept on read-back but ignored in the end comparison and in the saved limit.
- R9: A write of an address with either of bits 1:0 set to next, limit, start or stop leaves that register unchanged and sets the alignment-error flag.
- R10: Writes to next and limit are ignored while enable is set.
- R11: A command write with init-buffer (bit 6) clears the four saved copies (indices 5 to 8) without changing status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address, flag bit stripped) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory error response |
| per_valid_in | input | 1 | Peripheral word available (read direction) |
| per_data_in | input | 32 | Peripheral word in |
| per_ready_out | output | 1 | Channel accepts a peripheral word |
| per_valid_out | output | 1 | Channel offers a word to the peripheral |
| per_data_out | output | 32 | Word to the peripheral |
| per_ready_in | input | 1 | Peripheral accepts the offered word |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench sweeps segment lengths from zero up in read direction and every pairing of short chained segments in write direction, computing the expected memory image, peripheral stream, saved positions and byte counts arithmetically. A design that checked the limit after moving a word instead of before would write one word into a zero-length segment; one that dropped the chain or reloaded late would leave a gap or repeat words across the boundary, and one that kept bit 31 in the comparison would run past the limit. A bus error in the middle of a segment must stop on the failing word with that address saved, which catches a design that counts the failed word or keeps going. Misaligned address writes, writes to the active pair while running and a reset command mid-transfer must leave the read-back registers as they were, which exposes designs that latch bad addresses or let software corrupt a live pointer.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    // Register indices on the software port
    typedef enum logic [3:0] {
        RI_CTRL      = 4'd0,
        RI_CUR_NEXT  = 4'd1,
        RI_CUR_LIMIT = 4'd2,
        RI_Q_START   = 4'd3,
        RI_Q_STOP    = 4'd4,
        RI_SV_NEXT   = 4'd5,
        RI_SV_LIMIT  = 4'd6,
        RI_SV_START  = 4'd7,
        RI_SV_STOP   = 4'd8
    } reg_idx_e;

    // Command bit positions in a write to RI_CTRL
    localparam int CB_SET_EN    = 0;
    localparam int CB_SET_CHAIN = 1;
    localparam int CB_CLR_DONE  = 2;
    localparam int CB_SET_RD    = 3;
    localparam int CB_SET_WR    = 4;
    localparam int CB_RESET     = 5;
    localparam int CB_INIT      = 6;

    // Status flags; packed so that en lands in bit 0 of a read
    typedef struct packed {
        logic align_err;
        logic dir_rd;
        logic busexc;
        logic done;
        logic chain;
        logic en;
    } chan_flags_t;

    // Mover states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SRC   = 2'd2,
        ST_DST   = 2'd3
    } mv_state_e;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter bit TX_FLAG    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    input  logic              ev_step,
    input  logic              ev_end,
    input  logic              ev_err,
    output logic              en_o,
    output logic              dir_rd_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] next_m_o,
    output logic [ADDR_W-1:0] limit_m_o
);

    localparam int ALIGN_W = $clog2(WORD_BYTES);
    localparam int FLAG_W  = $bits(chan_flags_t);

    function automatic logic [ADDR_W-1:0] strip(input logic [ADDR_W-1:0] v);
        logic [ADDR_W-1:0] r;
        r = v;
        if (TX_FLAG) r[ADDR_W-1] = 1'b0;
        return r;
    endfunction

    chan_flags_t       flg;
    logic [ADDR_W-1:0] cur_next, cur_limit, q_start, q_stop;
    logic [ADDR_W-1:0] sv_next, sv_limit, sv_start, sv_stop;
    logic [ADDR_W-1:0] seg_base;

    logic wr_ctrl, cmd_reset, sw_set_en, aligned, seg_over;

    assign wr_ctrl   = wr_en && (wr_idx == RI_CTRL);
    assign cmd_reset = wr_ctrl && wdata[CB_RESET];
    assign sw_set_en = wr_ctrl && wdata[CB_SET_EN];
    assign aligned   = (wdata[ALIGN_W-1:0] == '0);
    assign seg_over  = ev_end || ev_err;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg       <= '0;
            cur_next  <= '0;
            cur_limit <= '0;
            q_start   <= '0;
            q_stop    <= '0;
            sv_next   <= '0;
            sv_limit  <= '0;
            sv_start  <= '0;
            sv_stop   <= '0;
            seg_base  <= '0;
        end else begin
            // events from the mover
            if (ev_step) cur_next <= cur_next + ADDR_W'(WORD_BYTES);
            if (seg_over) begin
                flg.done <= 1'b1;
                sv_next  <= seg_base;
                sv_limit <= strip(cur_next);
            end
            if (ev_err) begin
                flg.busexc <= 1'b1;
                flg.en     <= 1'b0;
            end
            if (ev_end) begin
                if (flg.chain) begin
                    cur_next  <= q_start;
                    cur_limit <= q_stop;
                    seg_base  <= q_start;
                    flg.chain <= 1'b0;
                end else begin
                    flg.en <= 1'b0;
                end
            end
            // software writes, applied after the events
            if (wr_en) begin
                case (wr_idx)
                    RI_CTRL: begin
                        if (wdata[CB_RESET]) begin
                            flg.en        <= 1'b0;
                            flg.chain     <= 1'b0;
                            flg.done      <= 1'b0;
                            flg.busexc    <= 1'b0;
                            flg.align_err <= 1'b0;
                        end else begin
                            if (wdata[CB_SET_EN])    flg.en    <= 1'b1;
                            if (wdata[CB_SET_CHAIN]) flg.chain <= 1'b1;
                            if (wdata[CB_CLR_DONE] && !seg_over) flg.done <= 1'b0;
                        end
                        if (wdata[CB_SET_RD] && !wdata[CB_SET_WR])      flg.dir_rd <= 1'b1;
                        else if (wdata[CB_SET_WR] && !wdata[CB_SET_RD]) flg.dir_rd <= 1'b0;
                        if (wdata[CB_INIT]) begin
                            sv_next  <= '0;
                            sv_limit <= '0;
                            sv_start <= '0;
                            sv_stop  <= '0;
                        end
                    end
                    RI_CUR_NEXT: begin
                        if (!flg.en) begin
                            if (aligned) begin
                                cur_next <= wdata;
                                seg_base <= wdata;
                            end else begin
                                flg.align_err <= 1'b1;
                            end
                        end
                    end
                    RI_CUR_LIMIT: begin
                        if (!flg.en) begin
                            if (aligned) cur_limit <= wdata;
                            else         flg.align_err <= 1'b1;
                        end
                    end
                    RI_Q_START: begin
                        if (aligned) q_start <= wdata;
                        else         flg.align_err <= 1'b1;
                    end
                    RI_Q_STOP: begin
                        if (aligned) q_stop <= wdata;
                        else         flg.align_err <= 1'b1;
                    end
                    RI_SV_NEXT:  sv_next  <= wdata;
                    RI_SV_LIMIT: sv_limit <= wdata;
                    RI_SV_START: sv_start <= wdata;
                    RI_SV_STOP:  sv_stop  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (wr_idx)
            RI_CTRL:      rdata = {{(ADDR_W-FLAG_W){1'b0}}, flg};
            RI_CUR_NEXT:  rdata = cur_next;
            RI_CUR_LIMIT: rdata = cur_limit;
            RI_Q_START:   rdata = q_start;
            RI_Q_STOP:    rdata = q_stop;
            RI_SV_NEXT:   rdata = sv_next;
            RI_SV_LIMIT:  rdata = sv_limit;
            RI_SV_START:  rdata = sv_start;
            RI_SV_STOP:   rdata = sv_stop;
            default:      rdata = '0;
        endcase
    end

    assign en_o      = flg.en;
    assign dir_rd_o  = flg.dir_rd;
    assign done_o    = flg.done;
    assign next_m_o  = strip(cur_next);
    assign limit_m_o = strip(cur_limit);

    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_step |=> cur_next == $past(cur_next) + ADDR_W'(WORD_BYTES)); // R2
    AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && flg.chain) |=> (cur_next == $past(q_start) && cur_limit == $past(q_stop))); // R5
    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && !flg.chain && !sw_set_en && !cmd_reset) |=> (!flg.en && flg.done)); // R4
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && !sw_set_en && !cmd_reset) |=> (flg.busexc && !flg.en)); // R7
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_next[ALIGN_W-1:0] == '0) && (q_start[ALIGN_W-1:0] == '0)); // R9
    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.en && wr_en && wr_idx == RI_CUR_LIMIT && !ev_end) |=> cur_limit == $past(cur_limit)); // R10

endmodule

// File: rtl/sgdma_mover.sv
module sgdma_mover
    import sgdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir_rd,
    input  logic [ADDR_W-1:0] next_m,
    input  logic [ADDR_W-1:0] limit_m,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              per_valid_in,
    input  logic [DATA_W-1:0] per_data_in,
    output logic              per_ready_out,
    output logic              per_valid_out,
    output logic [DATA_W-1:0] per_data_out,
    input  logic              per_ready_in,
    output logic              ev_step,
    output logic              ev_end,
    output logic              ev_err
);

    mv_state_e         state, state_nx;
    logic [DATA_W-1:0] hold_q;
    logic              at_lim;

    assign at_lim = (next_m >= limit_m);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (en) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (!en)         state_nx = ST_IDLE;
                else if (!at_lim) state_nx = ST_SRC;
            end
            ST_SRC: begin
                if (!en)                       state_nx = ST_IDLE;
                else if (dir_rd) begin
                    if (per_valid_in)          state_nx = ST_DST;
                end else if (mem_err)          state_nx = ST_IDLE;
                else if (mem_ack)              state_nx = ST_DST;
            end
            ST_DST: begin
                if (!en)                       state_nx = ST_IDLE;
                else if (dir_rd) begin
                    if (mem_err)               state_nx = ST_IDLE;
                    else if (mem_ack)          state_nx = ST_CHECK;
                end else if (per_ready_in)     state_nx = ST_CHECK;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        per_ready_out = 1'b0;
        per_valid_out = 1'b0;
        ev_step       = 1'b0;
        ev_end        = 1'b0;
        ev_err        = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CHECK: begin
                if (en && at_lim) ev_end = 1'b1;
            end
            ST_SRC: begin
                if (en) begin
                    if (dir_rd) begin
                        per_ready_out = 1'b1;
                    end else begin
                        mem_req = 1'b1;
                        if (mem_err) ev_err = 1'b1;
                    end
                end
            end
            ST_DST: begin
                if (en) begin
                    if (dir_rd) begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        if (mem_err)      ev_err  = 1'b1;
                        else if (mem_ack) ev_step = 1'b1;
                    end else begin
                        per_valid_out = 1'b1;
                        if (per_ready_in) ev_step = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // one-word holding register between source and destination
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state == ST_SRC && en) begin
            if (dir_rd && per_valid_in)                  hold_q <= per_data_in;
            else if (!dir_rd && mem_ack && !mem_err)     hold_q <= mem_rdata;
        end
    end

    assign mem_addr     = next_m;
    assign mem_wdata    = hold_q;
    assign per_data_out = hold_q;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_step, ev_end, ev_err})); // R2
    AST_IDLE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> state == ST_IDLE); // R7
    AST_WRITE_DIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> dir_rd); // R3
    AST_NO_MOVE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && en && at_lim) |=> state != ST_SRC); // R4

endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
    import sgdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter bit TX_FLAG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              per_valid_in,
    input  logic [DATA_W-1:0] per_data_in,
    output logic              per_ready_out,
    output logic              per_valid_out,
    output logic [DATA_W-1:0] per_data_out,
    input  logic              per_ready_in,
    output logic              irq
);

    localparam int WORD_BYTES = DATA_W / 8;

    logic              en, dir_rd, done;
    logic [ADDR_W-1:0] next_m, limit_m;
    logic              ev_step, ev_end, ev_err;

    sgdma_regs #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .TX_FLAG    (TX_FLAG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_idx    (reg_idx),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ev_step   (ev_step),
        .ev_end    (ev_end),
        .ev_err    (ev_err),
        .en_o      (en),
        .dir_rd_o  (dir_rd),
        .done_o    (done),
        .next_m_o  (next_m),
        .limit_m_o (limit_m)
    );

    sgdma_mover #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mover (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .dir_rd        (dir_rd),
        .next_m        (next_m),
        .limit_m       (limit_m),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .per_valid_in  (per_valid_in),
        .per_data_in   (per_data_in),
        .per_ready_out (per_ready_out),
        .per_valid_out (per_valid_out),
        .per_data_out  (per_data_out),
        .per_ready_in  (per_ready_in),
        .ev_step       (ev_step),
        .ev_end        (ev_end),
        .ev_err        (ev_err)
    );

    assign irq = done;

    AST_IRQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr_en) |=> irq); // R6

endmodule

// File: tb/sgdma_channel_bench.sv
module sgdma_channel_bench;

    localparam logic [31:0] C_EN = 32'h01, C_CHAIN = 32'h02, C_CLR = 32'h04,
                            C_RD = 32'h08, C_WR = 32'h10, C_RST = 32'h20, C_INIT = 32'h40;
    localparam logic [3:0]  I_CTRL = 4'd0, I_NEXT = 4'd1, I_LIMIT = 4'd2, I_START = 4'd3,
                            I_STOP = 4'd4, I_SVN = 4'd5, I_SVL = 4'd6, I_SVS = 4'd7, I_SVT = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_idx = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        per_valid_in, per_ready_out, per_valid_out, per_ready_in;
    logic [31:0] per_data_in, per_data_out;
    logic        irq;

    logic [31:0] mem [0:63];
    logic        fill_req = 1'b0;
    logic        err_arm = 1'b0;
    logic [31:0] err_addr = 32'd0;
    logic        pin_gate = 1'b1;
    logic        pout_gate = 1'b1;
    logic [31:0] pin_cnt = 32'd0;
    logic [31:0] pout [0:127];
    int          pout_n = 0;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input int i);
        return 32'hA000_0000 + 32'(i * 17);
    endfunction

    assign mem_err     = mem_req && err_arm && (mem_addr == err_addr);
    assign mem_ack     = mem_req && !mem_err;
    assign mem_rdata   = mem[mem_addr[7:2]];
    assign per_valid_in = pin_gate;
    assign per_data_in  = 32'h5000_0000 + pin_cnt;
    assign per_ready_in = pout_gate;

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 64; i++) mem[i] <= pat(i);
        end else if (mem_req && mem_we && mem_ack) begin
            mem[mem_addr[7:2]] <= mem_wdata;
        end
        if (per_valid_in && per_ready_out) pin_cnt <= pin_cnt + 1;
        if (per_valid_out && per_ready_in) begin
            pout[pout_n[6:0]] <= per_data_out;
            pout_n <= pout_n + 1;
        end
    end

    sgdma_channel #(.TX_FLAG(1'b1)) u_sgdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .per_valid_in(per_valid_in), .per_data_in(per_data_in),
        .per_ready_out(per_ready_out), .per_valid_out(per_valid_out),
        .per_data_out(per_data_out), .per_ready_in(per_ready_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_idx   = idx;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_fill();
        @(negedge clk);
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    // waits for irq high, returns status sampled in the same cycle
    task automatic wait_irq(input string req, output logic [31:0] st);
        bit seen;
        seen = 1'b0;
        st = 32'hFFFF_FFFF;
        reg_idx = I_CTRL;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (irq) begin
                seen = 1'b1;
                st = reg_rdata;
            end
        end
        chk(req, {31'd0, seen}, 32'd1);
    endtask

    task automatic start_seg(input logic [31:0] dir, input logic [31:0] nx, input logic [31:0] lm,
                             input logic [31:0] qs, input logic [31:0] qe, input bit arm);
        wr(I_CTRL, 32'd0);
        wr(I_CTRL, C_RST | C_INIT | dir);
        wr(I_NEXT, nx);
        wr(I_LIMIT, lm);
        wr(I_START, qs);
        wr(I_STOP, qe);
        wr(I_CTRL, C_EN | dir | (arm ? C_CHAIN : 32'd0));
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, st, svn, svl, c0;
        int p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_fill();

        // R1: reset state
        rd(I_CTRL, v);  chk("R1 status after reset", v, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(I_NEXT, v);  chk("R1 next after reset", v, 32'h0);

        // R11: init-buffer clears saved copies only
        for (int i = 0; i < 4; i++) wr(4'(I_SVN + i), 32'h1111_0000 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            rd(4'(I_SVN + i), v); chk("R11 saved written", v, 32'h1111_0000 + 32'(i));
        end
        wr(I_CTRL, C_INIT);
        for (int i = 0; i < 4; i++) begin
            rd(4'(I_SVN + i), v); chk("R11 saved cleared", v, 32'h0);
        end
        rd(I_CTRL, v); chk("R11 status unchanged", v, 32'h0);

        // R9: misaligned writes ignored and flagged
        wr(I_NEXT, 32'h100);
        wr(I_NEXT, 32'h102);
        rd(I_NEXT, v);  chk("R9 next kept", v, 32'h100);
        rd(I_CTRL, v);  chk("R9 align flag", v, 32'h20);
        wr(I_STOP, 32'h13);
        rd(I_STOP, v);  chk("R9 stop kept", v, 32'h0);
        wr(I_START, 32'h44);
        rd(I_START, v); chk("R9 aligned start", v, 32'h44);
        wr(I_CTRL, C_RST);
        rd(I_CTRL, v);  chk("R1 reset clears align", v, 32'h0);

        // R2 R4 R6 R8: read-direction sweep over lengths 0..5
        for (int n = 0; n < 6; n++) begin
            logic [31:0] lim;
            do_fill();
            lim = (32'h10 + 32'(4 * n)) | ((n % 2) == 1 ? 32'h8000_0000 : 32'h0);
            wr(I_CTRL, 32'd0);
            c0 = pin_cnt;
            start_seg(C_RD, 32'h10, lim, 32'h0, 32'h0, 1'b0);
            wait_irq("R4 end irq", st);
            chk("R4 status stopped", st, 32'h14);
            repeat (4) @(negedge clk);
            chk("R6 irq held", {31'd0, irq}, 32'd1);
            for (int k = 0; k < n; k++) chk("R2 word stored", mem[4 + k], 32'h5000_0000 + c0 + 32'(k));
            chk("R4 no word past limit", mem[4 + n], pat(4 + n));
            rd(I_SVN, svn); chk("R4 saved next", svn, 32'h10);
            rd(I_SVL, svl); chk("R8 R4 saved limit", svl, 32'h10 + 32'(4 * n));
            chk("R4 byte count", svl - svn, 32'(4 * n));
            rd(I_LIMIT, v); chk("R8 limit readback", v, lim);
            wr(I_CTRL, C_CLR | C_RD);
            chk("R6 irq cleared", {31'd0, irq}, 32'd0);
            rd(I_CTRL, v);  chk("R6 status cleared", v, 32'h10);
        end

        // R3 R5 R6: write-direction chained pairs
        for (int a = 1; a < 4; a++) begin
            for (int b = 2; b < 5; b++) begin
                logic [31:0] qe;
                do_fill();
                qe = (32'hC0 + 32'(4 * b)) | (b == 3 ? 32'h8000_0000 : 32'h0);
                p0 = pout_n;
                start_seg(C_WR, 32'h80, 32'h80 + 32'(4 * a), 32'hC0, qe, 1'b1);
                wait_irq("R5 first irq", st);
                chk("R5 status chained", st, 32'h05);
                wr(I_CTRL, C_CLR | C_WR);
                chk("R6 irq after ack", {31'd0, irq}, 32'd0);
                rd(I_LIMIT, v); chk("R5 limit from stop", v, qe);
                wait_irq("R5 second irq", st);
                chk("R5 status end", st, 32'h04);
                chk("R3 word count", 32'(pout_n - p0), 32'(a + b));
                for (int k = 0; k < a; k++) chk("R3 first segment data", pout[7'(p0 + k)], pat(32 + k));
                for (int k = 0; k < b; k++) chk("R5 second segment data", pout[7'(p0 + a + k)], pat(48 + k));
                rd(I_SVN, svn); chk("R5 saved next", svn, 32'hC0);
                rd(I_SVL, svl); chk("R8 saved limit", svl, 32'hC0 + 32'(4 * b));
                wr(I_CTRL, C_CLR | C_WR);
            end
        end

        // R7: bus error mid-segment
        do_fill();
        err_addr = 32'h28;
        err_arm  = 1'b1;
        wr(I_CTRL, 32'd0);
        c0 = pin_cnt;
        start_seg(C_RD, 32'h20, 32'h34, 32'h0, 32'h0, 1'b0);
        wait_irq("R7 irq", st);
        chk("R7 status", st, 32'h1C);
        rd(I_SVN, v);  chk("R7 saved next", v, 32'h20);
        rd(I_SVL, v);  chk("R7 saved limit", v, 32'h28);
        chk("R7 word0", mem[8], 32'h5000_0000 + c0);
        chk("R7 word1", mem[9], 32'h5000_0000 + c0 + 1);
        chk("R7 failed word", mem[10], pat(10));
        chk("R7 no later word", mem[11], pat(11));
        err_arm = 1'b0;
        wr(I_CTRL, C_RST | C_RD);
        rd(I_CTRL, v); chk("R1 reset clears error", v, 32'h10);

        // R10 R1: writes while running, then reset mid-transfer
        do_fill();
        pin_gate = 1'b0;
        start_seg(C_RD, 32'h40, 32'h50, 32'h0, 32'h0, 1'b0);
        repeat (5) @(negedge clk);
        rd(I_CTRL, v);  chk("R10 running", v, 32'h11);
        wr(I_NEXT, 32'h0);
        rd(I_NEXT, v);  chk("R10 next kept", v, 32'h40);
        wr(I_LIMIT, 32'h60);
        rd(I_LIMIT, v); chk("R10 limit kept", v, 32'h50);
        wr(I_CTRL, C_RST | C_RD);
        rd(I_CTRL, v);  chk("R1 stopped by reset", v, 32'h10);
        pin_gate = 1'b1;
        repeat (6) @(negedge clk);
        rd(I_CTRL, v);  chk("R1 stays stopped", v, 32'h10);
        chk("R1 no write after reset", mem[16], pat(16));
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule